// File: doc/BRIEF.md
# Bus hold request arbiter

This block is the bus-interface sequencer of a small processor whose bus cycles run through four states, T1 to T4. An external DMA master asks for the bus by raising a hold request. The sequencer decides on which clock it answers with hold acknowledge, stops driving the bus and hands it over. A bus cycle that has begun is never cut short. The clock on which the grant appears depends on two things: whether a cycle is running, and how late in that cycle the request was seen.

Internal logic asks for bus cycles with a one-clock strobe. The sequencer latches that strobe as a pending request and starts a cycle from it. While the bus is in T3, a pending request locks in a back-to-back cycle. A hold request seen at the edge that ends T2, or earlier, blocks that lock, and the bus is released in the clock after T4. A hold request that arrives later is only honoured after the T4 of the cycle that was locked in.

While the bus is granted, the status lines carry a fixed filler code with no meaning. The sequencer stays idle and keeps internal requests pending until the hold request is withdrawn.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A started cycle always steps T1, T2, T3, T4 on consecutive clocks, whatever holdReq does. The tState encoding is 0 for idle and 1 to 4 for T1 to T4.
- R2: With the sequencer idle, no grant active and no internal request pending, holdReq sampled high at an edge makes holdAck 1 after that same edge. At that point busDriveEn is 0 and tState is 0.
- R3: If holdReq is sampled high at the edge that ends T2 and is still high at the edge that ends T4, a request that was pending during T3 does not start a new cycle. holdAck rises after the T4 edge.
- R4: If an internal request is pending in T3 and holdReq was low at the edge that ends T2, the next cycle is locked in (status[1] is 1 during T4). T1 follows T4 even if holdReq is high at that point, and the grant comes only after the T4 of that next cycle.
- R5: If the sequencer is idle and an internal request is pending, that request takes precedence over holdReq. T1 follows at the next edge, and the grant waits for the T4 of that cycle.
- R6: When not granted, status is {T1 flag in bit 3, request pending in bit 2, next cycle locked in bit 1, cycle active in bit 0}. While holdAck is 1, status is 4'b1111, a code that cannot occur otherwise.
- R7: While holdAck is 1, tState stays 0 and busDriveEn stays 0. Internal strobes received during the grant stay pending and show in status[2] once the grant ends.
- R8: holdReq sampled low while granted clears holdAck at that edge. At the following edge, busDriveEn returns to 1 and a pending cycle enters T1. busDriveEn is 1 in every state T1 to T4.
- R9: After reset, holdAck is 0, tState is 0, busDriveEn is 1 and status is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdReq | input | 1 | Bus hold request from the DMA master (level) |
| cycReq | input | 1 | Internal bus-cycle request strobe |
| holdAck | output | 1 | Hold acknowledge: bus granted to the DMA master |
| busDriveEn | output | 1 | Enables the processor's bus drivers |
| tState | output | 3 | Current bus state, 0 idle, 1 to 4 for T1 to T4 |
| status | output | STATUS_W | Cycle status lines, filler code while granted |

## Verification
Some rules are checked on every cycle: the fixed T1 to T4 stepping, the quiet bus and filler status during a grant, the one-clock drop of the acknowledge, the grant clock after an unlocked T4 and in the idle case, and the precedence of a pending request in idle. The bench's scenarios are needed for the rest. Only they show the early-versus-late request timing around the T2 and T3 edges. They also show that requests made during a grant survive it, and that the drive enable returns one clock after the acknowledge falls. Long random runs of hold levels and request strobes are compared against a cycle model built from the requirements.

// File: rtl/holdarb_pkg.sv
package holdarb_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  // strobes from control to datapath, one clock wide each
  typedef struct packed {
    logic startCycle;  // next state is T1, consumes the pending request
    logic grantBus;    // hand the bus to the DMA master
    logic dropGrant;   // take the bus back
    logic lockNext;    // back-to-back cycle committed at end of T3
    logic clearLock;   // end of T4 retires the commit
  } seqStrobes_t;

endpackage

// File: rtl/hold_seq_ctrl.sv
module hold_seq_ctrl
  import holdarb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdReq,
  input  logic        pending,
  input  logic        committed,
  input  logic        holdSampled,
  input  logic        holdAck,
  output tstate_e     tState,
  output seqStrobes_t strobes
);

  tstate_e stateNext;
  logic    inIdle;
  logic    inT3;
  logic    inT4;

  assign inIdle = (tState == TS_IDLE);
  assign inT3   = (tState == TS_T3);
  assign inT4   = (tState == TS_T4);

  always_comb begin
    strobes = '0;
    // a pending request in idle outranks hold; at T4 a commit outranks hold
    strobes.grantBus = !holdAck && holdReq &&
                       ((inIdle && !pending) || (inT4 && !committed));
    strobes.startCycle = (inIdle && !holdAck && pending) ||
                         (inT4 && committed) ||
                         (inT4 && !committed && !holdReq && pending);
    strobes.dropGrant = holdAck && !holdReq;
    // hold seen by the end of T2 (holdSampled) vetoes the lock
    strobes.lockNext  = inT3 && pending && !holdSampled;
    strobes.clearLock = inT4;
  end

  always_comb begin
    stateNext = tState;
    unique case (tState)
      TS_IDLE: stateNext = strobes.startCycle ? TS_T1 : TS_IDLE;
      TS_T1:   stateNext = TS_T2;
      TS_T2:   stateNext = TS_T3;
      TS_T3:   stateNext = TS_T4;
      TS_T4:   stateNext = strobes.startCycle ? TS_T1 : TS_IDLE;
      default: stateNext = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) tState <= TS_IDLE;
    else       tState <= stateNext;
  end

endmodule

// File: rtl/hold_seq_dp.sv
module hold_seq_dp
  import holdarb_pkg::*;
#(
  parameter int                  STATUS_W   = 4,
  parameter logic [STATUS_W-1:0] GRANT_FILL = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                holdReq,
  input  logic                cycReq,
  input  seqStrobes_t         strobes,
  input  tstate_e             tState,
  output logic                pending,
  output logic                committed,
  output logic                holdSampled,
  output logic                holdAck,
  output logic                busDriveEn,
  output logic [STATUS_W-1:0] status
);

  localparam int FIELD_W = 4;

  logic [FIELD_W-1:0] fieldBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      committed   <= 1'b0;
      holdSampled <= 1'b0;
      holdAck     <= 1'b0;
      busDriveEn  <= 1'b1;
    end else begin
      pending     <= (pending && !strobes.startCycle) || cycReq;
      holdSampled <= holdReq;
      if (strobes.lockNext)       committed <= 1'b1;
      else if (strobes.clearLock) committed <= 1'b0;
      if (strobes.grantBus)       holdAck <= 1'b1;
      else if (strobes.dropGrant) holdAck <= 1'b0;
      // drivers come back one clock after the acknowledge falls
      busDriveEn <= !strobes.grantBus && !holdAck;
    end
  end

  assign fieldBits = {tState == TS_T1, pending, committed, tState != TS_IDLE};

  generate
    if (STATUS_W > FIELD_W) begin : g_wide
      always_comb begin
        status = holdAck ? GRANT_FILL
                         : {{(STATUS_W-FIELD_W){1'b0}}, fieldBits};
      end
    end else begin : g_exact
      always_comb begin
        status = holdAck ? GRANT_FILL : fieldBits[STATUS_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import holdarb_pkg::*;
#(
  parameter int                  STATUS_W   = 4,
  parameter logic [STATUS_W-1:0] GRANT_FILL = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                holdReq,
  input  logic                cycReq,
  output logic                holdAck,
  output logic                busDriveEn,
  output logic [2:0]          tState,
  output logic [STATUS_W-1:0] status
);

  tstate_e     seqState;
  seqStrobes_t seqStrobes;
  logic        pendingFlag;
  logic        commitFlag;
  logic        holdSampledFlag;

  hold_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .holdReq     (holdReq),
    .pending     (pendingFlag),
    .committed   (commitFlag),
    .holdSampled (holdSampledFlag),
    .holdAck     (holdAck),
    .tState      (seqState),
    .strobes     (seqStrobes)
  );

  hold_seq_dp #(
    .STATUS_W   (STATUS_W),
    .GRANT_FILL (GRANT_FILL)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .holdReq     (holdReq),
    .cycReq      (cycReq),
    .strobes     (seqStrobes),
    .tState      (seqState),
    .pending     (pendingFlag),
    .committed   (commitFlag),
    .holdSampled (holdSampledFlag),
    .holdAck     (holdAck),
    .busDriveEn  (busDriveEn),
    .status      (status)
  );

  assign tState = seqState;

endmodule

// File: rtl/hold_arb_checker.sv
module hold_arb_checker #(
  parameter int                  STATUS_W   = 4,
  parameter logic [STATUS_W-1:0] GRANT_FILL = '1
) (
  input logic                clk,
  input logic                rstN,
  input logic                holdReq,
  input logic                cycReq,
  input logic                holdAck,
  input logic                busDriveEn,
  input logic [2:0]          tState,
  input logic [STATUS_W-1:0] status
);

  logic unusedIn;
  assign unusedIn = cycReq;

  assert_cycle_steps_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd1 || tState == 3'd2 || tState == 3'd3) |=> (tState == $past(tState) + 3'd1))
    else $error("cycle did not step");

  assert_idle_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd0 && !holdAck && holdReq && !status[2]) |=> holdAck)
    else $error("idle grant missing");

  assert_unlocked_t4_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd4 && holdReq && !status[1]) |=> holdAck)
    else $error("grant after T4 missing");

  assert_late_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd3 && status[2] && !$past(holdReq)) |=> ##1 (tState == 3'd1))
    else $error("locked cycle not started");

  assert_idle_pending_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd0 && !holdAck && status[2]) |=> (tState == 3'd1 && !holdAck))
    else $error("pending request lost to hold");

  assert_fill_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (status == GRANT_FILL))
    else $error("status not filler while granted");

  assert_granted_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (tState == 3'd0 && !busDriveEn))
    else $error("bus active while granted");

  assert_drop_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq) |=> (!holdAck && !busDriveEn))
    else $error("acknowledge did not drop");

  assert_drive_in_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tState != 3'd0) |-> busDriveEn)
    else $error("cycle without drive");

endmodule

bind bus_hold_arbiter hold_arb_checker #(
  .STATUS_W   (STATUS_W),
  .GRANT_FILL (GRANT_FILL)
) u_chk (.*);

// File: tb/bus_hold_arbiter_test.sv
`timescale 1ns/1ps
module bus_hold_arbiter_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       holdReq;
  logic       cycReq;
  logic       holdAck;
  logic       busDriveEn;
  logic [2:0] tState;
  logic [3:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // cycle model built from the requirements
  int mState;
  bit mPend, mCommit, mHoldS, mAck, mDrive;

  always #2.5 clk = ~clk;

  bus_hold_arbiter uut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .cycReq(cycReq),
    .holdAck(holdAck), .busDriveEn(busDriveEn), .tState(tState), .status(status)
  );

  task automatic checkEq(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expStatus();
    if (mAck) return 4'b1111;
    return {mState == 1, mPend, mCommit, mState != 0};
  endfunction

  task automatic modelReset();
    mState = 0; mPend = 0; mCommit = 0; mHoldS = 0; mAck = 0; mDrive = 1;
  endtask

  task automatic modelStep(input bit h, input bit c);
    bit grant, start, lock, newAck;
    grant  = !mAck && h && ((mState == 0 && !mPend) || (mState == 4 && !mCommit));
    start  = (mState == 0 && !mAck && mPend) ||
             (mState == 4 && (mCommit || (!h && mPend)));
    lock   = (mState == 3) && mPend && !mHoldS;
    newAck = grant ? 1'b1 : ((mAck && !h) ? 1'b0 : mAck);
    mDrive = !grant && !mAck;
    if (start)                         mState = 1;
    else if (mState >= 1 && mState <= 3) mState = mState + 1;
    else                               mState = 0;
    mPend   = (mPend && !start) || c;
    mCommit = lock ? 1'b1 : ((mState == 1 || mState == 0) ? 1'b0 : mCommit);
    mHoldS  = h;
    mAck    = newAck;
  endtask

  task automatic compareAll();
    checkEq("R1", "tState", 32'(tState), 32'(mState));
    checkEq("R2", "holdAck", 32'(holdAck), 32'(mAck));
    checkEq("R8", "busDriveEn", 32'(busDriveEn), 32'(mDrive));
    checkEq("R6", "status", 32'(status), 32'(expStatus()));
  endtask

  task automatic tick(input bit h, input bit c);
    holdReq = h;
    cycReq  = c;
    @(posedge clk);
    modelStep(h, c);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; holdReq = 1'b0; cycReq = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkEq("R9", "holdAck", 32'(holdAck), 0);
    checkEq("R9", "tState", 32'(tState), 0);
    checkEq("R9", "busDriveEn", 32'(busDriveEn), 1);
    checkEq("R9", "status", 32'(status), 0);

    // idle grant, request during grant, release and resume
    tick(1, 0);
    checkEq("R2", "idle grant ack", 32'(holdAck), 1);
    checkEq("R2", "idle grant drive", 32'(busDriveEn), 0);
    checkEq("R6", "filler", 32'(status), 32'hF);
    tick(1, 1);
    checkEq("R7", "idle while granted", 32'(tState), 0);
    tick(0, 0);
    checkEq("R8", "ack dropped", 32'(holdAck), 0);
    checkEq("R8", "drive still off", 32'(busDriveEn), 0);
    checkEq("R7", "request kept pending", 32'(status), 32'b0100);
    tick(0, 0);
    checkEq("R8", "resume T1", 32'(tState), 1);
    checkEq("R8", "drive back", 32'(busDriveEn), 1);
    tick(1, 0);
    checkEq("R1", "T2 despite hold", 32'(tState), 2);
    tick(0, 0); tick(0, 0); tick(0, 0);
    checkEq("R1", "back to idle", 32'(tState), 0);

    // early hold blocks the back-to-back cycle
    tick(0, 1); tick(0, 0); tick(0, 1);
    tick(1, 0);
    tick(1, 0);
    checkEq("R3", "no lock in T4", 32'(status[1]), 0);
    tick(1, 0);
    checkEq("R3", "grant after T4", 32'(holdAck), 1);
    tick(0, 0); tick(0, 0);
    checkEq("R3", "deferred cycle T1", 32'(tState), 1);
    tick(0, 0); tick(0, 0); tick(0, 0); tick(0, 0);

    // late hold: locked cycle runs first
    tick(0, 1); tick(0, 0); tick(0, 1); tick(0, 0);
    tick(1, 0);
    checkEq("R4", "locked status", 32'(status), 32'b0111);
    tick(1, 0);
    checkEq("R4", "no grant, T1", 32'({holdAck, tState}), 32'b0001);
    tick(1, 0); tick(1, 0); tick(1, 0);
    checkEq("R4", "second T4", 32'(tState), 4);
    tick(1, 0);
    checkEq("R4", "grant after second T4", 32'(holdAck), 1);
    tick(0, 0); tick(0, 0);

    // pending in idle beats hold
    tick(0, 1);
    tick(1, 0);
    checkEq("R5", "cycle starts first", 32'({holdAck, tState}), 32'b0001);
    tick(1, 0); tick(1, 0); tick(1, 0);
    tick(1, 0);
    checkEq("R5", "grant after its T4", 32'(holdAck), 1);
    tick(0, 0); tick(0, 0);

    // random phase
    begin
      int seed;
      bit h;
      seed = $urandom(32'h5EED_1234);
      h = 0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 8) == 0) h = !h;
        tick(h, ($urandom % 3) == 0);
      end
      if (seed == 0) h = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule